// File: doc/BRIEF.md
# Sampling converter conversion and interrupt controller

This block sequences the conversions of a sampling converter and handles the host side of reading the results. The host has three active-low controls: a conversion-start line, a chip-select and a read strobe. The block gives back one active-low status line, a track/hold control and the read data word. The block does not model the analog track/hold or the comparator. It treats a conversion as a fixed number of clock cycles. In the last of those cycles it captures the 12-bit code supplied on its result input.

The block works in one of two modes, and the host chooses the mode through the way it wires the conversion-start line. In timer mode, something outside the block (typically a precise timer) pulses the conversion-start line low. The return of that line to high begins the sample, unless chip-select is asserted at that moment. The status line then acts as an interrupt: it goes low when a result is ready and stays low until the host reads. In processor mode, the conversion-start line is held low, so the falling edge of chip-select starts the conversion. The status line then acts as a busy flag for as long as the conversion runs.

The host can read the result either as a whole 12-bit word or as two bytes. In byte format, a byte-select input chooses the low byte or the high nibble of the result. The read-data latches keep their previous contents until a conversion finishes.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `status_n` is 1 and `hold` is 0. `dout` is 0 whenever no read is active.
- R2: In timer mode, a rising edge on `start_n` that a clock samples while `sel_n` is 1 starts a conversion. `hold` is 1 from the next cycle on.
- R3: A rising edge on `start_n` that a clock samples while `sel_n` is 0 starts no conversion, and `hold` stays 0.
- R4: A start request that arrives while a conversion is running is ignored. The running conversion keeps its length.
- R5: A conversion lasts `CONV_CYCLES` cycles (13 by default). During those cycles `hold` is 1. The value on `result_in` is captured in the final cycle, and after that `hold` returns to 0 (tracking).
- R6: In timer mode, `status_n` stays 1 while the conversion runs. It goes to 0 in the cycle after the conversion ends and stays 0 until the host reads.
- R7: The interrupt is cleared, so that `status_n` returns to 1, on the clock edge that first sees `sel_n` and `rd_n` both at 0.
- R8: A read made while a conversion is running returns the result of the previous conversion.
- R9: In processor mode, a falling edge on `sel_n` with `start_n` at 0 starts a conversion. `status_n` is then 0 for the whole conversion and returns to 1 when the conversion ends.
- R10: With `byte_fmt` at 0, a read (`sel_n` and `rd_n` both 0) puts all 12 result bits on `dout`, and `byte_hi` has no effect.
- R11: With `byte_fmt` at 1, a read with `byte_hi` at 0 gives the low 8 result bits on `dout[7:0]`, with `dout[11:8]` at 0. A read with `byte_hi` at 1 gives result bits 11 to 8 on `dout[3:0]`, with `dout[11:4]` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Conversion-start request, active low; a rising edge starts a conversion, or the line is held low for processor mode |
| sel_n | input | 1 | Chip-select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_fmt | input | 1 | 1 selects the two-byte read format, 0 selects the 12-bit format |
| byte_hi | input | 1 | Byte select in byte format: 1 reads the high nibble, 0 reads the low byte |
| result_in | input | 12 | Conversion code, captured in the final conversion cycle |
| status_n | output | 1 | Interrupt (timer mode) or busy flag (processor mode), active low |
| hold | output | 1 | 1 puts the track/hold in hold, 0 in tracking |
| dout | output | 12 | Read data; 0 when no read is active |

## Verification
Some properties are checked by the assertions on every cycle. The conversion counter stays in range. The read-data latch stays frozen while a conversion runs. An accepted start always raises hold, and a start edge made while chip-select is low is always refused. The interrupt sets at the end of a conversion and clears on a read strobe. The padding bits in byte reads stay zero.

Other behaviours need the bench's scenarios. These are the exact conversion length, and a second start that arrives part-way through a conversion and must be dropped. They also include the interrupt staying low across idle cycles until the host reads, and the old data returned by reads made during a conversion. The bench also checks the correct data in each read format, and a complete processor-mode conversion with its busy window.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;
  localparam int HI_W   = RES_W - BYTE_W;

  typedef logic [RES_W-1:0] code_t;

  // Arrange the held code for the bus according to the selected read format
  function automatic code_t fmt_read(code_t code, logic byte_mode, logic hi_sel);
    code_t w;
    if (!byte_mode)   w = code;
    else if (hi_sel)  w = {{(RES_W-HI_W){1'b0}}, code[RES_W-1 -: HI_W]};
    else              w = {{(RES_W-BYTE_W){1'b0}}, code[BYTE_W-1:0]};
    return w;
  endfunction
endpackage

// File: rtl/adc_start_detect.sv
module adc_start_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic sel_n,
  input  logic rd_n,
  output logic tmr_rise,
  output logic tmr_blocked,
  output logic cpu_fall,
  output logic strobe_fall
);
  logic start_q, sel_q, strobe_q, strobe_now;

  assign strobe_now = ~sel_n & ~rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b1;
      sel_q    <= 1'b1;
      strobe_q <= 1'b0;
    end else begin
      start_q  <= start_n;
      sel_q    <= sel_n;
      strobe_q <= strobe_now;
    end
  end

  // Rising edge of the start line, accepted only with chip-select released
  assign tmr_rise    = start_n & ~start_q & sel_n;
  assign tmr_blocked = start_n & ~start_q & ~sel_n;
  // Chip-select falling while start is held low: processor-driven start
  assign cpu_fall    = ~sel_n & sel_q & ~start_n;
  assign strobe_fall = strobe_now & ~strobe_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CONV_CYCLES = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tmr_req,
  input  logic                       cpu_req,
  input  adc_ctrl_pkg::code_t        result_in,
  output logic                       busy,
  output logic                       accept,
  output logic                       done,
  output logic                       mode_cpu,
  output adc_ctrl_pkg::code_t        data_q
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign accept = (tmr_req | cpu_req) & ~busy;
  assign done   = busy & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      mode_cpu <= 1'b0;
      data_q   <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cnt      <= '0;
      mode_cpu <= cpu_req;
    end else if (done) begin
      busy     <= 1'b0;
      cnt      <= '0;
      data_q   <= result_in;
    end else if (busy) begin
      cnt      <= cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5
  AST_DATA_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(data_q)); // R8
  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R2
  AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5
endmodule

// File: rtl/adc_irq.sv
module adc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (clr_evt) pend <= 1'b0;
  end

  AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend); // R6
  AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !pend); // R7
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
  parameter int CONV_CYCLES = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_n,
  input  logic        sel_n,
  input  logic        rd_n,
  input  logic        byte_fmt,
  input  logic        byte_hi,
  input  logic [11:0] result_in,
  output logic        status_n,
  output logic        hold,
  output logic [11:0] dout
);
  import adc_ctrl_pkg::*;

  logic  tmr_rise, tmr_blocked, cpu_fall, strobe_fall;
  logic  busy, accept, done, mode_cpu, irq_pend, rd_active;
  code_t data_q;

  adc_start_detect u_det (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .sel_n(sel_n), .rd_n(rd_n),
    .tmr_rise(tmr_rise), .tmr_blocked(tmr_blocked), .cpu_fall(cpu_fall),
    .strobe_fall(strobe_fall)
  );

  adc_conv_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tmr_req(tmr_rise), .cpu_req(cpu_fall),
    .result_in(result_in), .busy(busy), .accept(accept), .done(done),
    .mode_cpu(mode_cpu), .data_q(data_q)
  );

  adc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(done & ~mode_cpu),
    .clr_evt(strobe_fall), .pend(irq_pend)
  );

  assign rd_active = ~sel_n & ~rd_n;
  assign hold      = busy;
  assign status_n  = mode_cpu ? ~busy : ~irq_pend;
  assign dout      = rd_active ? fmt_read(data_q, byte_fmt, byte_hi) : '0;

  AST_BLOCKED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_blocked && !busy) |=> !hold); // R3
  AST_CPU_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_fall && !busy) |=> !status_n); // R9
  AST_HI_NIBBLE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && byte_fmt && byte_hi) |-> (dout[11:4] == 8'h00)); // R11
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |-> (dout == 12'h000)); // R10
endmodule

// File: tb/adc_conv_ctrl_tb.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, sel_n = 1'b1, rd_n = 1'b1, byte_fmt = 1'b0, byte_hi = 1'b0;
  logic [11:0] result_in = 12'h000;
  logic status_n, hold;
  logic [11:0] dout;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_conv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .sel_n(sel_n), .rd_n(rd_n),
    .byte_fmt(byte_fmt), .byte_hi(byte_hi), .result_in(result_in),
    .status_n(status_n), .hold(hold), .dout(dout)
  );

  typedef struct packed {
    logic [11:0] res;
    logic        fmt;
    logic        hi;
    logic [11:0] exp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{12'hABC, 1'b0, 1'b0, 12'hABC},
    '{12'hABC, 1'b1, 1'b0, 12'h0BC},
    '{12'hABC, 1'b1, 1'b1, 12'h00A},
    '{12'h000, 1'b0, 1'b0, 12'h000},
    '{12'hFFF, 1'b1, 1'b1, 12'h00F},
    '{12'hFFF, 1'b1, 1'b0, 12'h0FF},
    '{12'h5A3, 1'b0, 1'b1, 12'h5A3}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Timer-mode conversion; returns at the first negedge after hold fell
  task automatic run_timer(input logic [11:0] code);
    result_in = code;
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(1);
    step(13);
  endtask

  task automatic do_read(input logic f, input logic h, output logic [11:0] val);
    byte_fmt = f; byte_hi = h;
    sel_n = 1'b0; rd_n = 1'b0; step(1);
    val = dout;
    sel_n = 1'b1; rd_n = 1'b1; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] v;
    step(2);
    // R1: reset state
    chk("R1 status", {11'd0, status_n}, 12'd1);
    chk("R1 hold", {11'd0, hold}, 12'd0);
    chk("R1 dout", dout, 12'h000);
    rst_n = 1'b1; step(2);
    chk("R1 status after release", {11'd0, status_n}, 12'd1);

    // R2 / R5 / R6: timer conversion timing
    result_in = 12'h3C5;
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(1);
    chk("R2 hold after start", {11'd0, hold}, 12'd1);
    step(4);
    chk("R6 status high while converting", {11'd0, status_n}, 12'd1);
    step(8);
    chk("R5 hold in last cycle", {11'd0, hold}, 12'd1);
    step(1);
    chk("R5 hold back to track", {11'd0, hold}, 12'd0);
    chk("R6 interrupt low at end", {11'd0, status_n}, 12'd0);
    step(5);
    chk("R6 interrupt persists", {11'd0, status_n}, 12'd0);
    do_read(1'b0, 1'b0, v);
    chk("R5 captured code", v, 12'h3C5);
    chk("R7 interrupt cleared by read", {11'd0, status_n}, 12'd1);

    // Vector table: conversion, format, read
    for (int i = 0; i < 7; i++) begin
      run_timer(VEC[i].res);
      chk("R6 interrupt per vector", {11'd0, status_n}, 12'd0);
      do_read(VEC[i].fmt, VEC[i].hi, v);
      chk(VEC[i].fmt ? "R11 byte read" : "R10 word read", v, VEC[i].exp);
      chk("R7 cleared per vector", {11'd0, status_n}, 12'd1);
    end

    // R3: start edge while chip-select low is refused
    sel_n = 1'b0; step(1);
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(1);
    chk("R3 no conversion", {11'd0, hold}, 12'd0);
    step(3);
    chk("R3 still tracking", {11'd0, hold}, 12'd0);
    sel_n = 1'b1; step(2);

    // R4: second start mid-conversion ignored
    result_in = 12'h777;
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(5);
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(7);
    chk("R4 length kept", {11'd0, hold}, 12'd1);
    step(1);
    chk("R4 ends on time", {11'd0, hold}, 12'd0);
    step(3);
    chk("R4 no restart", {11'd0, hold}, 12'd0);
    do_read(1'b0, 1'b0, v);
    chk("R4 code", v, 12'h777);

    // R8: read during conversion returns previous code
    result_in = 12'h456;
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(3);
    do_read(1'b0, 1'b0, v);
    chk("R8 old data mid-conversion", v, 12'h777);
    step(12);
    do_read(1'b0, 1'b0, v);
    chk("R8 new data after end", v, 12'h456);

    // R9: processor mode, chip-select starts, busy for whole conversion
    result_in = 12'h9E7; byte_fmt = 1'b0;
    start_n = 1'b0; sel_n = 1'b0; rd_n = 1'b0; step(1);
    chk("R9 busy at start", {11'd0, status_n}, 12'd0);
    chk("R9 hold at start", {11'd0, hold}, 12'd1);
    chk("R8 old data in processor mode", dout, 12'h456);
    step(12);
    chk("R9 busy through last cycle", {11'd0, status_n}, 12'd0);
    step(1);
    chk("R9 busy released", {11'd0, status_n}, 12'd1);
    chk("R9 new data", dout, 12'h9E7);
    start_n = 1'b1; step(1);
    sel_n = 1'b1; rd_n = 1'b1; step(2);
    chk("R9 idle afterwards", {11'd0, hold}, 12'd0);
    chk("R1 bus idle", dout, 12'h000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule